// File: doc/BRIEF.md
# Program Counter with Circular Return Stack

This block holds the instruction fetch address of a small 8-bit controller core. A 13-bit counter steps forward on request and loads absolute targets for jumps and calls. Taking an interrupt sends it to a fixed vector, and returns take their address from an eight-level hardware stack. Calls and interrupts share that stack. The fetch address it presents is folded into the program memory that is physically present, whose size is a parameter (512 or 2048 words in the intended uses).

Each cycle at most one action takes effect, chosen by a fixed priority among the strobes. A return can also carry an 8-bit literal. The block hands that literal out on a side port with a one-cycle load pulse, so that logic elsewhere can write it into the working register. Decode, the program memory, interrupt enabling and page-select bits are not part of this block.

Top module: `pcs_core`

## Requirements
- R1: While `rst_n` is low, the PC is 0000h, the stack pointer is at slot 0, all stack slots hold 0, `lit_out` is 0 and `lit_load` is 0. `fetch_addr` reads 0 in the first cycle after reset.
- R2: `fetch_addr` equals the 13-bit PC ANDed with (MEM_WORDS − 1). The PC itself is 13 bits and steps from 1FFFh to 0000h.
- R3: With `adv` as the only strobe, the PC becomes PC+1 at the next edge. With no strobe, the PC holds.
- R4: `jmp` loads `target` into the PC at the next edge and leaves the stack unchanged.
- R5: `call` pushes PC+1 onto the stack and loads `target` into the PC.
- R6: `ret` pops the stack and loads the popped address into the PC. Nested calls return in last-in, first-out order.
- R7: The stack is circular with eight slots. A ninth push overwrites the oldest entry. A pop from an empty stack returns the slot below the pointer (modulo 8) and raises no flag, which gives 0000h right after reset.
- R8: `irq_take` pushes the current PC (the instruction not executed) and loads 0004h.
- R9: When strobes coincide, the priority is `irq_take`, then `ret`, then `call`, then `jmp`, then `adv`. Only the winning action changes the PC or the stack.
- R10: A winning `ret` with `lit_en` high makes `lit_out` equal `lit_in` and `lit_load` 1 for exactly one cycle. In every other cycle `lit_load` is 0 and `lit_out` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| adv | input | 1 | Step to the next sequential address |
| jmp | input | 1 | Load `target` |
| call | input | 1 | Push PC+1, then load `target` |
| ret | input | 1 | Pop and load the popped address |
| lit_en | input | 1 | Qualifies `ret` as a return with literal |
| irq_take | input | 1 | Push the current PC, then load the interrupt vector |
| target | input | 13 | Absolute jump or call address |
| lit_in | input | 8 | Literal carried by a return |
| fetch_addr | output | 13 | PC folded into the implemented memory |
| lit_out | output | 8 | Last returned literal |
| lit_load | output | 1 | One-cycle pulse when `lit_out` is refreshed |

## Verification
The bench builds two copies of the block on shared inputs. One uses MEM_WORDS=512 and the other MEM_WORDS=2048, so a single stimulus shows both folding masks. Stepping through all 8192 PC values and jumping to every 13-bit target covers the wrap of each folded window and the PC's own rollover. With an eight-deep stack, nine nested calls followed by nine returns are enough to reach the overwrite of the oldest entry and a pop past empty.

// File: rtl/pcs_pkg.sv
package pcs_pkg;

   // action chosen for the current cycle
   typedef enum logic [2:0] {
      PA_HOLD = 3'd0,
      PA_STEP = 3'd1,
      PA_JUMP = 3'd2,
      PA_CALL = 3'd3,
      PA_RET  = 3'd4,
      PA_IRQ  = 3'd5
   } pc_act_e;

   function automatic logic act_pushes(input pc_act_e a);
      return (a == PA_CALL) || (a == PA_IRQ);
   endfunction

   function automatic logic act_pops(input pc_act_e a);
      return (a == PA_RET);
   endfunction

endpackage

// File: rtl/pcs_arbiter.sv
module pcs_arbiter
   import pcs_pkg::*;
(
   input  logic    adv,
   input  logic    jmp,
   input  logic    call,
   input  logic    ret,
   input  logic    irq_take,
   output pc_act_e act,
   output logic    push,
   output logic    pop
);

   // fixed priority: interrupt, return, call, jump, step
   always_comb begin
      if (irq_take)  act = PA_IRQ;
      else if (ret)  act = PA_RET;
      else if (call) act = PA_CALL;
      else if (jmp)  act = PA_JUMP;
      else if (adv)  act = PA_STEP;
      else           act = PA_HOLD;
   end

   assign push = act_pushes(act);
   assign pop  = act_pops(act);

endmodule

// File: rtl/pcs_ret_stack.sv
module pcs_ret_stack #(
   parameter int DEPTH = 8,
   parameter int DW    = 13
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          push,
   input  logic          pop,
   input  logic [DW-1:0] push_data,
   output logic [DW-1:0] pop_data
);

   localparam int SP_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH < 2 || DEPTH != (1 << SP_W)) begin : g_bad_depth
         $error("pcs_ret_stack: DEPTH must be a power of two of at least 2");
      end
   endgenerate

   logic [SP_W-1:0] sp;
   logic [SP_W-1:0] sp_dn;
   logic [DW-1:0]   slot [DEPTH];

   assign sp_dn    = sp - SP_W'(1);
   assign pop_data = slot[sp_dn];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    sp <= '0;
      else if (push) sp <= sp + SP_W'(1);
      else if (pop)  sp <= sp_dn;
   end

   // one register per slot; the write pointer wraps so the oldest entry is reused
   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            slot[g] <= '0;
         else if (push && (sp == SP_W'(g)))
            slot[g] <= push_data;
      end
   end

   // R5 / R8: a push advances the pointer and stores the data
   a_r5_push_step: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (sp == $past(sp) + SP_W'(1)));

   a_r5_push_stored: assert property (@(posedge clk) disable iff (!rst_n)
      push |=> (slot[$past(sp)] == $past(push_data)));

   // R6 / R7: a pop steps the pointer back, wrapping below slot 0
   a_r6_pop_step: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !push) |=> (sp == $past(sp) - SP_W'(1)));

endmodule

// File: rtl/pcs_fold.sv
module pcs_fold #(
   parameter int PC_W      = 13,
   parameter int MEM_WORDS = 512
) (
   input  logic [PC_W-1:0] pc,
   output logic [PC_W-1:0] addr
);

   localparam int AW = $clog2(MEM_WORDS);
   localparam logic [PC_W-1:0] MASK = PC_W'(MEM_WORDS - 1);

   generate
      if (MEM_WORDS < 2 || MEM_WORDS != (1 << AW) || AW > PC_W) begin : g_bad_size
         $error("pcs_fold: MEM_WORDS must be a power of two no larger than 2**PC_W");
      end
      if (AW == PC_W) begin : g_full
         assign addr = pc;
      end else begin : g_wrap
         assign addr = pc & MASK;
      end
   endgenerate

endmodule

// File: rtl/pcs_core.sv
module pcs_core
   import pcs_pkg::*;
#(
   parameter int PC_W      = 13,
   parameter int MEM_WORDS = 512,
   parameter int DEPTH     = 8,
   parameter int LIT_W     = 8,
   parameter int RESET_VEC = 0,
   parameter int IRQ_VEC   = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             jmp,
   input  logic             call,
   input  logic             ret,
   input  logic             lit_en,
   input  logic             irq_take,
   input  logic [PC_W-1:0]  target,
   input  logic [LIT_W-1:0] lit_in,
   output logic [PC_W-1:0]  fetch_addr,
   output logic [LIT_W-1:0] lit_out,
   output logic             lit_load
);

   localparam logic [PC_W-1:0] RST_PC = PC_W'(RESET_VEC);
   localparam logic [PC_W-1:0] IRQ_PC = PC_W'(IRQ_VEC);

   generate
      if (RESET_VEC == IRQ_VEC) begin : g_bad_vec
         $error("pcs_core: reset and interrupt vectors must differ");
      end
   endgenerate

   pc_act_e         act;
   logic            push;
   logic            pop;
   logic [PC_W-1:0] pc;
   logic [PC_W-1:0] pc_inc;
   logic [PC_W-1:0] pc_nxt;
   logic [PC_W-1:0] push_data;
   logic [PC_W-1:0] pop_data;

   pcs_arbiter u_arb (
      .adv      (adv),
      .jmp      (jmp),
      .call     (call),
      .ret      (ret),
      .irq_take (irq_take),
      .act      (act),
      .push     (push),
      .pop      (pop)
   );

   // an interrupt saves the instruction it displaced, a call saves its successor
   assign pc_inc    = pc + PC_W'(1);
   assign push_data = (act == PA_IRQ) ? pc : pc_inc;

   pcs_ret_stack #(.DEPTH(DEPTH), .DW(PC_W)) u_stk (
      .clk       (clk),
      .rst_n     (rst_n),
      .push      (push),
      .pop       (pop),
      .push_data (push_data),
      .pop_data  (pop_data)
   );

   always_comb begin
      unique case (act)
         PA_IRQ:           pc_nxt = IRQ_PC;
         PA_RET:           pc_nxt = pop_data;
         PA_CALL, PA_JUMP: pc_nxt = target;
         PA_STEP:          pc_nxt = pc_inc;
         default:          pc_nxt = pc;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pc <= RST_PC;
      else        pc <= pc_nxt;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lit_out  <= '0;
         lit_load <= 1'b0;
      end else begin
         lit_load <= (act == PA_RET) && lit_en;
         if ((act == PA_RET) && lit_en) lit_out <= lit_in;
      end
   end

   pcs_fold #(.PC_W(PC_W), .MEM_WORDS(MEM_WORDS)) u_fold (
      .pc   (pc),
      .addr (fetch_addr)
   );

   // R8: a taken interrupt lands on its vector
   a_r8_irq_vector: assert property (@(posedge clk) disable iff (!rst_n)
      irq_take |=> (pc == IRQ_PC));

   // R9: a return beats a simultaneous call and takes the stacked address
   a_r9_ret_over_call: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && call && !irq_take) |=> (pc == $past(pop_data)));

   // R4: a lone jump loads the target
   a_r4_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
      (jmp && !call && !ret && !irq_take) |=> (pc == $past(target)));

   // R3: no strobe leaves the PC alone
   a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(adv || jmp || call || ret || irq_take) |=> $stable(pc));

   // R10: a literal return refreshes the side output for one cycle
   a_r10_lit_capture: assert property (@(posedge clk) disable iff (!rst_n)
      (ret && lit_en && !irq_take) |=> (lit_load && lit_out == $past(lit_in)));

   a_r10_lit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(ret && lit_en && !irq_take) |=> (!lit_load && $stable(lit_out)));

endmodule

// File: tb/tb_pcs_core.sv
module tb_pcs_core;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        adv = 0, jmp = 0, call = 0, ret = 0, lit_en = 0, irq_take = 0;
   logic [12:0] target = '0;
   logic [7:0]  lit_in = '0;
   logic [12:0] f_s, f_w;
   logic [7:0]  lo_s, lo_w;
   logic        ll_s, ll_w;

   int n_chk = 0;
   int n_bad = 0;
   bit done  = 0;

   // reference model state
   logic [12:0] m_pc;
   logic [12:0] m_stk [8];
   int          m_sp;
   logic [7:0]  m_lit;
   logic        m_ll;

   always #(CLK_PERIOD/2) clk = ~clk;

   pcs_core #(.MEM_WORDS(512)) dut (
      .clk(clk), .rst_n(rst_n), .adv(adv), .jmp(jmp), .call(call), .ret(ret),
      .lit_en(lit_en), .irq_take(irq_take), .target(target), .lit_in(lit_in),
      .fetch_addr(f_s), .lit_out(lo_s), .lit_load(ll_s));

   pcs_core #(.MEM_WORDS(2048)) dut_w (
      .clk(clk), .rst_n(rst_n), .adv(adv), .jmp(jmp), .call(call), .ret(ret),
      .lit_en(lit_en), .irq_take(irq_take), .target(target), .lit_in(lit_in),
      .fetch_addr(f_w), .lit_out(lo_w), .lit_load(ll_w));

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic model_reset();
      m_pc = 13'h0000; m_sp = 0; m_lit = '0; m_ll = 0;
      for (int k = 0; k < 8; k++) m_stk[k] = '0;
   endtask

   task automatic check_outs(input string tag);
      chk({tag, " fetch512"},  {19'd0, f_s}, {19'd0, m_pc & 13'h01FF});
      chk({tag, " fetch2048"}, {19'd0, f_w}, {19'd0, m_pc & 13'h07FF});
      chk("R10 lit_load", {31'd0, ll_s}, {31'd0, m_ll});
      chk("R10 lit_out",  {24'd0, lo_s}, {24'd0, m_lit});
      chk("R10 lit_load wide", {31'd0, ll_w}, {31'd0, m_ll});
   endtask

   // called at a negedge: drive, predict, cross the edge, compare
   task automatic cyc(input logic a, input logic j, input logic c, input logic r,
                      input logic l, input logic i, input logic [12:0] t,
                      input logic [7:0] li, input string tag);
      logic [12:0] inc;
      adv = a; jmp = j; call = c; ret = r; lit_en = l; irq_take = i;
      target = t; lit_in = li;
      inc  = m_pc + 13'd1;
      m_ll = 0;
      if (i) begin
         m_stk[m_sp] = m_pc; m_sp = (m_sp + 1) % 8; m_pc = 13'h0004;
      end else if (r) begin
         m_sp = (m_sp + 7) % 8; m_pc = m_stk[m_sp];
         if (l) begin m_lit = li; m_ll = 1; end
      end else if (c) begin
         m_stk[m_sp] = inc; m_sp = (m_sp + 1) % 8; m_pc = t;
      end else if (j) begin
         m_pc = t;
      end else if (a) begin
         m_pc = inc;
      end
      @(posedge clk); #1;
      check_outs(tag);
      @(negedge clk);
   endtask

   task automatic idle(input string tag);
      cyc(0, 0, 0, 0, 0, 0, 13'h0, 8'h0, tag);
   endtask

   task automatic do_reset();
      rst_n = 0;
      adv = 0; jmp = 0; call = 0; ret = 0; lit_en = 0; irq_take = 0;
      model_reset();
      @(posedge clk); #1;
      check_outs("R1 reset");
      @(negedge clk);
      rst_n = 1;
      @(posedge clk); #1;
      check_outs("R1 after reset");
      @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
         $finish;
      end
   end

   initial begin
      model_reset();
      @(negedge clk);
      do_reset();

      // R2, R3: walk every PC value and past the 13-bit rollover
      for (int k = 0; k < 8200; k++) cyc(1, 0, 0, 0, 0, 0, 13'h0, 8'h0, "R2 R3 step");
      for (int k = 0; k < 3; k++) idle("R3 hold");

      // R4: every 13-bit target
      for (int k = 0; k < 8192; k++) cyc(0, 1, 0, 0, 0, 0, 13'(k), 8'h0, "R4 jump");

      // R7: pop from empty after reset gives 0000h
      do_reset();
      cyc(0, 0, 0, 1, 0, 0, 13'h0, 8'h0, "R7 empty pop");

      // R5, R6: nested calls, last in first out
      cyc(0, 1, 0, 0, 0, 0, 13'h0123, 8'h0, "R4 setup");
      for (int k = 0; k < 6; k++) cyc(0, 0, 1, 0, 0, 0, 13'(16'h0400 + k * 16'h0333), 8'h0, "R5 call");
      for (int k = 0; k < 6; k++) cyc(0, 0, 0, 1, 0, 0, 13'h0, 8'h0, "R6 ret");

      // R7: nine nested calls overwrite the oldest, then nine pops
      do_reset();
      cyc(0, 1, 0, 0, 0, 0, 13'h1F00, 8'h0, "R4 setup");
      for (int k = 0; k < 9; k++) cyc(0, 0, 1, 0, 0, 0, 13'(16'h0210 + k * 16'h0101), 8'h0, "R7 call");
      for (int k = 0; k < 9; k++) cyc(0, 0, 0, 1, 0, 0, 13'h0, 8'h0, "R7 ret");

      // R8: interrupt saves the displaced PC, return resumes it
      cyc(0, 1, 0, 0, 0, 0, 13'h0777, 8'h0, "R4 setup");
      cyc(1, 0, 0, 0, 0, 1, 13'h0, 8'h0, "R8 irq");
      cyc(1, 0, 0, 0, 0, 0, 13'h0, 8'h0, "R8 handler step");
      cyc(0, 0, 0, 1, 0, 0, 13'h0, 8'h0, "R8 return");

      // R10: return with literal, then a plain return holds the literal
      cyc(0, 0, 1, 0, 0, 0, 13'h0055, 8'h0, "R5 call");
      cyc(0, 0, 1, 0, 0, 0, 13'h0066, 8'h0, "R5 call");
      cyc(0, 0, 0, 1, 1, 0, 13'h0, 8'hA5, "R10 lit ret");
      idle("R10 pulse end");
      cyc(0, 0, 0, 1, 0, 0, 13'h0, 8'h3C, "R10 plain ret");
      cyc(0, 0, 0, 0, 1, 0, 13'h0, 8'h77, "R10 lit_en alone");

      // R9: every strobe combination from a known state
      for (int s = 1; s < 32; s++) begin
         cyc(0, 1, 0, 0, 0, 0, 13'(16'h0100 + s), 8'h0, "R4 setup");
         cyc(0, 0, 1, 0, 0, 0, 13'(16'h0A00 + s), 8'h0, "R5 prime");
         cyc(s[0], s[1], s[2], s[3], 1'b1, s[4], 13'(16'h1234 + s), 8'(s), "R9 priority");
         cyc(0, 0, 0, 1, 0, 0, 13'h0, 8'h0, "R9 follow pop");
      end

      // R1: reset mid-run clears the stack slots
      cyc(0, 0, 1, 0, 0, 0, 13'h0999, 8'h0, "R5 call");
      do_reset();
      cyc(0, 0, 0, 1, 0, 0, 13'h0, 8'h0, "R1 stack cleared");

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule